// File: doc/BRIEF.md
# Transmit mailbox scheduler for a CAN controller

This block holds a small bank of transmit mailboxes for a CAN controller and decides which of them is handed next to the bit-level transmit engine. Software fills a mailbox through a simple write port. It sets the mailbox mode and a 4-bit priority, the identifier and eight data bytes. It then writes a command word that requests the transfer. The four mailboxes sit at absolute indices 12 to 15, after the receive mailboxes of the controller.

Whenever the engine is idle, the block looks at every pending mailbox that is in transmit mode. It picks the one with the numerically smallest priority value and, on a tie, the lowest index. It presents that frame with a one-cycle start strobe. The engine answers with done, lost or abort. A lost arbitration or an error leaves the request pending, so it competes again against everything else that is pending. A done or an abort frees the mailbox, updates its ready and abort flags, and raises its interrupt bit. Software may also withdraw a request that has not reached the engine yet.

Top module: `can_txmb_sched`

## Requirements
- R1: After reset every mailbox reports ready=1 and abort=0, all interrupt bits are 0 and tx_start is 0.
- R2: Register selects are 0 mode, 1 identifier, 2 data bytes 0..3, 3 data bytes 4..7 and 4 command. In the mode word, bits 26:24 hold the mode (0 disabled, 3 transmit) and bits 19:16 hold the priority. In the command word, bit 23 requests a transfer, bit 22 withdraws a request, bit 20 is RTR and bits 19:16 are the DLC. A transfer request is taken only when the mailbox is ready and in transmit mode. Taking it clears ready, the abort flag and the mailbox interrupt bit.
- R3: With the engine idle, a request written at clock edge N makes tx_start high for exactly the one cycle after edge N+1. In that cycle the outputs show the mailbox index (12..15), the identifier (bits 28:0 of the identifier word), the extended flag (bit 29), RTR, DLC and the data (bytes 0..3 in tx_data[31:0]).
- R4: Among eligible pending mailboxes, the one with the smallest priority value is started first.
- R5: Among eligible mailboxes of equal priority, the lowest index is started first.
- R6: From a start until the engine responds, the frame outputs stay unchanged and no further start is issued.
- R7: An engine done sets the mailbox's ready to 1 and abort to 0 at the next edge, and sets irq bit 12+k for mailbox k. No other irq bit is ever set.
- R8: An engine lost leaves the mailbox pending (ready=0). The mailbox is then arbitrated again against all pending mailboxes.
- R9: An engine abort sets both ready and abort of the active mailbox and raises its irq bit.
- R10: A withdraw command on a pending mailbox that is not with the engine sets ready and abort and raises its irq bit at the next edge, and the frame is never started. A withdraw on the mailbox the engine holds is ignored.
- R11: An identifier write is ignored unless the mailbox mode is disabled. Identifier and data writes are ignored while the mailbox has a request outstanding.
- R12: A pending mailbox whose mode is not transmit is skipped by arbitration. It becomes eligible again once transmit mode is restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_mb | input | 4 | Absolute mailbox index (12..15 used) |
| wr_reg | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| eng_done | input | 1 | Engine: active frame sent |
| eng_lost | input | 1 | Engine: arbitration lost or error, retry |
| eng_abort | input | 1 | Engine: active frame aborted |
| tx_start | output | 1 | One-cycle start strobe for the engine |
| tx_mb | output | 4 | Index of the active mailbox |
| tx_id | output | 29 | Identifier of the active frame |
| tx_ide | output | 1 | Extended identifier flag |
| tx_rtr | output | 1 | Remote request flag |
| tx_dlc | output | 4 | Data length code |
| tx_data | output | 64 | Data bytes, byte 0 in bits 7:0 |
| mb_ready | output | 4 | Per-mailbox ready flag |
| mb_abort | output | 4 | Per-mailbox abort flag |
| irq | output | 16 | Interrupt bits, mailbox k at bit 12+k |

## Verification
A request written at one edge is stored at that edge. It is arbitrated at the following edge, so tx_start is checked in the cycle after the second edge. An engine response or a withdraw command updates the ready, abort and irq outputs at the edge that samples it, and the next start appears one edge later. Every check is therefore taken on the falling edge of exactly that cycle. The directed tasks hold the engine busy with one frame while the others are queued, so that priority, tie-break, retry and mode-skip ordering are all decided in a single arbitration step.

// File: rtl/can_txmb_sched.sv
module can_txmb_sched #(
  parameter int NUM_MB   = 4,
  parameter int FIRST_MB = 12,
  parameter int IDX_W    = 4,
  parameter int IRQ_W    = 16,
  parameter int PRIO_W   = 4,
  parameter int ID_W     = 29,
  parameter int DLC_W    = 4
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_mb,
  input  logic [2:0]         wr_reg,
  input  logic [31:0]        wr_data,
  input  logic               eng_done,
  input  logic               eng_lost,
  input  logic               eng_abort,
  output logic               tx_start,
  output logic [IDX_W-1:0]   tx_mb,
  output logic [ID_W-1:0]    tx_id,
  output logic               tx_ide,
  output logic               tx_rtr,
  output logic [DLC_W-1:0]   tx_dlc,
  output logic [63:0]        tx_data,
  output logic [NUM_MB-1:0]  mb_ready,
  output logic [NUM_MB-1:0]  mb_abort,
  output logic [IRQ_W-1:0]   irq
);
  localparam int SEL_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1;
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(FIRST_MB);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FIRST_MB + NUM_MB - 1);

  localparam logic [2:0] R_MODE = 3'd0, R_ID = 3'd1, R_DLO = 3'd2, R_DHI = 3'd3, R_CMD = 3'd4;
  localparam logic [2:0] MODE_OFF = 3'd0, MODE_TX = 3'd3;
  localparam int B_MODE = 24, B_PRIO = 16, B_REQ = 23, B_WDR = 22, B_RTR = 20, B_DLC = 16, B_IDE = 29;

  logic [2:0]        mode_q [NUM_MB];
  logic [PRIO_W-1:0] prio_q [NUM_MB];
  logic [ID_W-1:0]   id_q   [NUM_MB];
  logic [63:0]       data_q [NUM_MB];
  logic [DLC_W-1:0]  dlc_q  [NUM_MB];
  logic [NUM_MB-1:0] ide_q, rtr_q, pend_q, ready_q, abort_q, evt_q;

  logic              busy_q, start_q;
  logic [SEL_W-1:0]  act_q;

  logic              wr_in;
  logic [SEL_W-1:0]  wr_sel;
  logic              eng_any;
  logic [NUM_MB-1:0] hit, act_oh, req_ok, wdr_ok, fin, elig;

  assign wr_in   = wr_en && (wr_mb >= FIRST_IDX) && (wr_mb <= LAST_IDX);
  assign wr_sel  = SEL_W'(wr_mb - FIRST_IDX);
  assign eng_any = eng_done || eng_lost || eng_abort;

  always_comb begin
    for (int i = 0; i < NUM_MB; i++) begin
      hit[i]    = wr_in && (wr_sel == SEL_W'(i));
      act_oh[i] = busy_q && (act_q == SEL_W'(i));
      req_ok[i] = hit[i] && (wr_reg == R_CMD) && wr_data[B_REQ] &&
                  ready_q[i] && (mode_q[i] == MODE_TX);
      wdr_ok[i] = hit[i] && (wr_reg == R_CMD) && !wr_data[B_REQ] && wr_data[B_WDR] &&
                  pend_q[i] && !act_oh[i];
      fin[i]    = act_oh[i] && (eng_done || eng_abort);
      elig[i]   = pend_q[i] && (mode_q[i] == MODE_TX) && !wdr_ok[i];
    end
  end

  logic              found;
  logic [SEL_W-1:0]  best;
  logic [PRIO_W-1:0] best_prio;

  always_comb begin
    found     = 1'b0;
    best      = '0;
    best_prio = '1;
    for (int i = 0; i < NUM_MB; i++) begin
      if (elig[i] && (!found || prio_q[i] < best_prio)) begin
        found     = 1'b1;
        best      = SEL_W'(i);
        best_prio = prio_q[i];
      end
    end
  end

  wire arb_go = !busy_q && found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_MB; i++) begin
        mode_q[i] <= MODE_OFF;
        prio_q[i] <= '0;
        id_q[i]   <= '0;
        data_q[i] <= '0;
        dlc_q[i]  <= '0;
      end
      ide_q   <= '0;
      rtr_q   <= '0;
      pend_q  <= '0;
      ready_q <= '1;
      abort_q <= '0;
      evt_q   <= '0;
    end else begin
      for (int i = 0; i < NUM_MB; i++) begin
        if (hit[i] && wr_reg == R_MODE) begin
          mode_q[i] <= wr_data[B_MODE +: 3];
          prio_q[i] <= wr_data[B_PRIO +: PRIO_W];
        end
        if (hit[i] && wr_reg == R_ID && ready_q[i] && mode_q[i] == MODE_OFF) begin
          id_q[i]  <= wr_data[ID_W-1:0];
          ide_q[i] <= wr_data[B_IDE];
        end
        if (hit[i] && wr_reg == R_DLO && ready_q[i]) data_q[i][31:0]  <= wr_data;
        if (hit[i] && wr_reg == R_DHI && ready_q[i]) data_q[i][63:32] <= wr_data;

        if (req_ok[i]) begin
          pend_q[i]  <= 1'b1;
          ready_q[i] <= 1'b0;
          abort_q[i] <= 1'b0;
          evt_q[i]   <= 1'b0;
          dlc_q[i]   <= wr_data[B_DLC +: DLC_W];
          rtr_q[i]   <= wr_data[B_RTR];
        end else if (wdr_ok[i]) begin
          pend_q[i]  <= 1'b0;
          ready_q[i] <= 1'b1;
          abort_q[i] <= 1'b1;
          evt_q[i]   <= 1'b1;
        end else if (fin[i]) begin
          pend_q[i]  <= 1'b0;
          ready_q[i] <= 1'b1;
          abort_q[i] <= !eng_done;
          evt_q[i]   <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      act_q   <= '0;
    end else begin
      start_q <= arb_go;
      if (arb_go) begin
        busy_q <= 1'b1;
        act_q  <= best;
      end else if (busy_q && eng_any) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign tx_start = start_q;
  assign tx_mb    = FIRST_IDX + IDX_W'(act_q);
  assign tx_id    = id_q[act_q];
  assign tx_ide   = ide_q[act_q];
  assign tx_rtr   = rtr_q[act_q];
  assign tx_dlc   = dlc_q[act_q];
  assign tx_data  = data_q[act_q];
  assign mb_ready = ready_q;
  assign mb_abort = abort_q;
  assign irq      = IRQ_W'(evt_q) << FIRST_MB;
endmodule

// File: rtl/can_txmb_sched_chk.sv
module can_txmb_sched_chk #(
  parameter int NUM_MB   = 4,
  parameter int FIRST_MB = 12,
  parameter int IDX_W    = 4,
  parameter int IRQ_W    = 16,
  parameter int ID_W     = 29
)(
  input logic              clk,
  input logic              rst_n,
  input logic              tx_start,
  input logic [IDX_W-1:0]  tx_mb,
  input logic [ID_W-1:0]   tx_id,
  input logic [63:0]       tx_data,
  input logic              eng_done,
  input logic              eng_lost,
  input logic              eng_abort,
  input logic [NUM_MB-1:0] mb_ready,
  input logic [NUM_MB-1:0] mb_abort,
  input logic [IRQ_W-1:0]  irq
);
  localparam int SEL_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1;

  logic             inflight;
  logic [SEL_W-1:0] cur;
  wire resp = eng_done || eng_lost || eng_abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight <= 1'b0;
      cur      <= '0;
    end else if (tx_start) begin
      inflight <= 1'b1;
      cur      <= SEL_W'(tx_mb - IDX_W'(FIRST_MB));
    end else if (resp) begin
      inflight <= 1'b0;
    end
  end

  a_r3_start_owned: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> !mb_ready[SEL_W'(tx_mb - IDX_W'(FIRST_MB))]);

  a_r6_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  a_r6_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight && !resp) |=> ($stable(tx_mb) && $stable(tx_id) && $stable(tx_data) && !tx_start));

  a_r7_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight && eng_done) |=> (mb_ready[cur] && !mb_abort[cur]));

  a_r8_lost_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight && eng_lost && !eng_done && !eng_abort) |=> !mb_ready[cur]);

  a_r9_abort_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight && eng_abort && !eng_done) |=> (mb_ready[cur] && mb_abort[cur]));

  a_r7_irq_implies_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (irq[FIRST_MB +: NUM_MB] & ~mb_ready) == '0);
endmodule

bind can_txmb_sched can_txmb_sched_chk #(
  .NUM_MB(NUM_MB), .FIRST_MB(FIRST_MB), .IDX_W(IDX_W), .IRQ_W(IRQ_W), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_mb(tx_mb), .tx_id(tx_id),
  .tx_data(tx_data), .eng_done(eng_done), .eng_lost(eng_lost), .eng_abort(eng_abort),
  .mb_ready(mb_ready), .mb_abort(mb_abort), .irq(irq)
);

// File: tb/sim_can_txmb_sched.sv
module sim_can_txmb_sched;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_mb = '0;
  logic [2:0] wr_reg = '0;
  logic [31:0] wr_data = '0;
  logic eng_done = 1'b0, eng_lost = 1'b0, eng_abort = 1'b0;
  logic tx_start, tx_ide, tx_rtr;
  logic [3:0] tx_mb, tx_dlc, mb_ready, mb_abort;
  logic [28:0] tx_id;
  logic [63:0] tx_data;
  logic [15:0] irq;

  int n_chk = 0, n_fail = 0;

  can_txmb_sched u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mb(wr_mb), .wr_reg(wr_reg), .wr_data(wr_data),
    .eng_done(eng_done), .eng_lost(eng_lost), .eng_abort(eng_abort),
    .tx_start(tx_start), .tx_mb(tx_mb), .tx_id(tx_id), .tx_ide(tx_ide), .tx_rtr(tx_rtr),
    .tx_dlc(tx_dlc), .tx_data(tx_data), .mb_ready(mb_ready), .mb_abort(mb_abort), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] mb, input logic [2:0] rg, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_mb = mb; wr_reg = rg; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_mode(input logic [3:0] mb, input logic [2:0] md, input logic [3:0] pr);
    wr(mb, 3'd0, {5'b0, md, 4'b0, pr, 16'h0});
  endtask

  task automatic load(input logic [3:0] mb, input logic [3:0] pr, input logic [28:0] id,
                      input logic ide, input logic [31:0] dlo, input logic [31:0] dhi);
    set_mode(mb, 3'd0, pr);
    wr(mb, 3'd1, {2'b0, ide, id});
    set_mode(mb, 3'd3, pr);
    wr(mb, 3'd2, dlo);
    wr(mb, 3'd3, dhi);
  endtask

  task automatic req(input logic [3:0] mb, input logic [3:0] dlc, input logic rtr);
    wr(mb, 3'd4, {8'h0, 1'b1, 1'b0, 1'b0, rtr, dlc, 16'h0});
  endtask

  task automatic withdraw(input logic [3:0] mb);
    wr(mb, 3'd4, {8'h0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 16'h0});
  endtask

  task automatic respond(input int kind);
    @(negedge clk);
    eng_done = (kind == 0); eng_lost = (kind == 1); eng_abort = (kind == 2);
    @(negedge clk);
    eng_done = 1'b0; eng_lost = 1'b0; eng_abort = 1'b0;
  endtask

  task automatic expect_start(input string tag, input logic [3:0] mb);
    @(negedge clk);
    chk({tag, " start"}, 64'(tx_start), 64'd1);
    chk({tag, " mailbox"}, 64'(tx_mb), 64'(mb));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready", 64'(mb_ready), 64'hF);
    chk("R1 abort", 64'(mb_abort), 64'h0);
    chk("R1 irq", 64'(irq), 64'h0);
    chk("R1 start", 64'(tx_start), 64'h0);
  endtask

  task automatic t_single();
    load(4'd13, 4'd5, 29'h1234567, 1'b1, 32'h03020100, 32'h07060504);
    req(4'd13, 4'd8, 1'b0);
    chk("R3 no early start", 64'(tx_start), 64'd0);
    expect_start("R3", 4'd13);
    chk("R3 id", 64'(tx_id), 64'h1234567);
    chk("R3 ide", 64'(tx_ide), 64'd1);
    chk("R3 dlc", 64'(tx_dlc), 64'd8);
    chk("R3 rtr", 64'(tx_rtr), 64'd0);
    chk("R3 data", tx_data, 64'h0706050403020100);
    chk("R2 ready cleared", 64'(mb_ready), 64'b1101);
    @(negedge clk);
    chk("R3 one-cycle strobe", 64'(tx_start), 64'd0);
    respond(0);
    chk("R7 ready", 64'(mb_ready), 64'hF);
    chk("R7 abort", 64'(mb_abort), 64'h0);
    chk("R7 irq", 64'(irq), 64'h2000);
  endtask

  task automatic t_prio();
    load(4'd12, 4'd0, 29'h11, 1'b0, 32'h0, 32'h0);
    req(4'd12, 4'd1, 1'b0);
    expect_start("R4 first", 4'd12);
    load(4'd13, 4'd9, 29'h13, 1'b0, 32'h0, 32'h0);
    req(4'd13, 4'd1, 1'b0);
    chk("R2 irq bit cleared by request", 64'(irq), 64'h0);
    load(4'd14, 4'd3, 29'h14, 1'b0, 32'h0, 32'h0);
    req(4'd14, 4'd1, 1'b0);
    load(4'd15, 4'd3, 29'h15, 1'b0, 32'h0, 32'h0);
    req(4'd15, 4'd1, 1'b0);
    respond(0);
    expect_start("R4 R5 tie lowest index", 4'd14);
    respond(0);
    expect_start("R5 tie second", 4'd15);
    respond(0);
    expect_start("R4 lowest priority last", 4'd13);
    respond(0);
    chk("R7 all done", 64'(mb_ready), 64'hF);
    chk("R7 irq range", 64'(irq), 64'hF000);
  endtask

  task automatic t_lost();
    load(4'd13, 4'd8, 29'h0ABCDEF, 1'b0, 32'hCAFE0013, 32'h0);
    req(4'd13, 4'd4, 1'b0);
    expect_start("R8 initial", 4'd13);
    load(4'd15, 4'd1, 29'h15, 1'b0, 32'h0, 32'h0);
    req(4'd15, 4'd1, 1'b0);
    respond(1);
    chk("R8 still pending", 64'(mb_ready[1]), 64'd0);
    expect_start("R8 rearbitrated", 4'd15);
    respond(0);
    expect_start("R8 retried", 4'd13);
    chk("R8 retried id", 64'(tx_id), 64'h0ABCDEF);
    respond(0);
  endtask

  task automatic t_withdraw();
    req(4'd12, 4'd1, 1'b0);
    expect_start("R10 setup", 4'd12);
    req(4'd14, 4'd1, 1'b0);
    withdraw(4'd14);
    chk("R10 ready", 64'(mb_ready[2]), 64'd1);
    chk("R10 abort", 64'(mb_abort[2]), 64'd1);
    chk("R10 irq", 64'(irq[14]), 64'd1);
    withdraw(4'd12);
    chk("R10 active ready", 64'(mb_ready[0]), 64'd0);
    chk("R10 active abort", 64'(mb_abort[0]), 64'd0);
    respond(0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 withdrawn never starts", 64'(tx_start), 64'd0);
    end
  endtask

  task automatic t_eng_abort();
    req(4'd12, 4'd1, 1'b0);
    expect_start("R9 setup", 4'd12);
    respond(2);
    chk("R9 ready", 64'(mb_ready[0]), 64'd1);
    chk("R9 abort", 64'(mb_abort[0]), 64'd1);
    chk("R9 irq", 64'(irq[12]), 64'd1);
    req(4'd12, 4'd1, 1'b0);
    chk("R2 abort cleared", 64'(mb_abort[0]), 64'd0);
    chk("R2 irq cleared", 64'(irq[12]), 64'd0);
    expect_start("R9 resend", 4'd12);
    respond(0);
  endtask

  task automatic t_id_guard();
    wr(4'd13, 3'd1, {2'b0, 1'b1, 29'h1555});
    req(4'd13, 4'd2, 1'b1);
    expect_start("R11 setup", 4'd13);
    chk("R11 id kept", 64'(tx_id), 64'h0ABCDEF);
    chk("R11 ide kept", 64'(tx_ide), 64'd0);
    chk("R3 rtr", 64'(tx_rtr), 64'd1);
    chk("R3 dlc", 64'(tx_dlc), 64'd2);
    wr(4'd13, 3'd2, 32'hDEADBEEF);
    chk("R11 data kept", 64'(tx_data[31:0]), 64'hCAFE0013);
    respond(0);
  endtask

  task automatic t_mode_skip();
    req(4'd12, 4'd1, 1'b0);
    expect_start("R12 setup", 4'd12);
    load(4'd14, 4'd1, 29'h14, 1'b0, 32'h0, 32'h0);
    req(4'd14, 4'd1, 1'b0);
    load(4'd15, 4'd5, 29'h15, 1'b0, 32'h0, 32'h0);
    req(4'd15, 4'd1, 1'b0);
    set_mode(4'd14, 3'd0, 4'd1);
    respond(0);
    expect_start("R12 disabled skipped", 4'd15);
    respond(0);
    chk("R12 still pending", 64'(mb_ready[2]), 64'd0);
    set_mode(4'd14, 3'd3, 4'd1);
    expect_start("R12 restored", 4'd14);
    respond(0);
    chk("R12 done", 64'(mb_ready), 64'hF);
  endtask

  task automatic t_mode_gate();
    set_mode(4'd13, 3'd0, 4'd0);
    req(4'd13, 4'd1, 1'b0);
    chk("R2 request ignored when disabled", 64'(mb_ready[1]), 64'd1);
    @(negedge clk);
    chk("R2 no start when disabled", 64'(tx_start), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_prio();
    t_lost();
    t_withdraw();
    t_eng_abort();
    t_id_guard();
    t_mode_skip();
    t_mode_gate();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule